// File: doc/BRIEF.md
# Instruction-Pair Fetch/Execute Sequencer

This block is the sequencing part of a control unit for a 40-bit accumulator machine. Each memory word packs two 20-bit instructions. An instruction is an 8-bit opcode followed by a 12-bit address. The sequencer keeps a pair counter that points at the next word to fetch, and it fetches that word over a single-port synchronous memory. It executes the left-hand instruction first, holding the right-hand one in a buffer register. It then runs the buffered instruction without another memory access, and only after that does it fetch again.

The sequencer decodes five groups of operations. Accumulator loads come in four variants, which it hands to an external arithmetic unit through a strobe, a mode code and an operand bus. It also handles the accumulator store, unconditional jumps, sign-conditional jumps, and address-field rewrites. A jump names a word and a half, so control can enter a word at its right-hand instruction. The field rewrite is a read-modify-write that replaces one 12-bit address field of a word and keeps the rest. Opcodes outside these groups pass through as no-ops. A hold input parks the sequencer at the boundary between instruction pairs.

Bit numbering on the ports is conventional: bit 39 is the most significant. The left instruction is [39:20], with opcode [39:32] and address [31:20]. The right instruction is [19:0], with opcode [19:12] and address [11:0]. The accumulator sign is bit 39.

Top module: `pair_sequencer`

States:
- `ST_IDLE`: the pair boundary. The machine holds here while `halt_i` is high.
- `ST_FETCH`: issues a read at the pair counter.
- `ST_FWAIT`: waits for the word to arrive.
- `ST_EXEC`: decodes the current instruction.
- `ST_OPRD`: issues the operand read.
- `ST_OWAIT`: waits for the operand.
- `ST_WRITE`: issues the memory write.
- `ST_NEXT`: takes the buffered right-hand instruction, or returns to `ST_IDLE`.

Transitions:
- `ST_IDLE` to `ST_FETCH` when `halt_i` is low.
- `ST_FETCH` to `ST_FWAIT`.
- `ST_FWAIT` to `ST_EXEC` on valid data.
- `ST_EXEC` to `ST_OPRD` for a load or a field rewrite.
- `ST_EXEC` to `ST_WRITE` for a store.
- `ST_EXEC` to `ST_NEXT` for anything else.
- `ST_OPRD` to `ST_OWAIT`.
- `ST_OWAIT` to `ST_WRITE` (field rewrite) or to `ST_NEXT` (load), on valid data.
- `ST_WRITE` to `ST_NEXT`.
- `ST_NEXT` to `ST_EXEC` if a right-hand instruction is buffered; otherwise to `ST_IDLE`.

## Requirements
- R1: After reset no memory read or write and no accumulator strobe occurs while `halt_i` is high, and the first read after halt is released is from address 0.
- R2: A fetched word runs its left instruction and then its right instruction with no further fetch of that word, and the next fetch is from the following address.
- R3: Opcodes 0x01, 0x02, 0x03 and 0x04 read word X and pulse `acc_load_o` with that word on `acc_opnd_o`. The pulse comes in the cycle `mem_rvalid_i` returns it. The mode codes are 0 (plain), 1 (negated), 2 (absolute) and 3 (negated absolute), respectively.
- R4: Opcode 0x21 writes `acc_i` to word X.
- R5: Opcode 0x0D continues with the left instruction of word X, skipping any right instruction still buffered.
- R6: Opcode 0x0E fetches word X and runs only its right instruction, then fetches word X+1.
- R7: Opcodes 0x0F (to the left half) and 0x10 (to the right half) jump like R5 and R6 when `acc_i[39]` is 0. When `acc_i[39]` is 1 they fall through to the next instruction.
- R8: Opcode 0x12 reads word X and writes it back with bits [31:20] replaced by `acc_i[11:0]`. Opcode 0x13 does the same for bits [11:0]. All other bits keep their old value.
- R9: Any other opcode makes no memory access and no accumulator strobe, and execution continues with the next instruction.
- R10: With `halt_i` high at a pair boundary, the sequencer issues no memory access until `halt_i` falls, and then it resumes with the next pair.
- R11: A read and a write are never issued together, a read is never issued two cycles in a row, and each read is waited on until `mem_rvalid_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt_i | input | 1 | Hold at the next pair boundary |
| mem_addr_o | output | 12 | Memory word address |
| mem_rd_o | output | 1 | Read request |
| mem_wr_o | output | 1 | Write request |
| mem_wdata_o | output | 40 | Write data |
| mem_rdata_i | input | 40 | Read data, valid with `mem_rvalid_i` |
| mem_rvalid_i | input | 1 | Read data valid |
| acc_i | input | 40 | Current accumulator value from the arithmetic unit |
| acc_load_o | output | 1 | Accumulator load strobe |
| acc_mode_o | output | 2 | Load variant: 0 plain, 1 negated, 2 absolute, 3 negated absolute |
| acc_opnd_o | output | 40 | Load operand |

## Verification
The assertions assume a well-behaved memory. It answers each read with exactly one `mem_rvalid_i` pulse, one cycle later, and it never raises `mem_rvalid_i` unasked. The assertions also assume `acc_i` changes only as a result of the sequencer's own load strobes. The bench memory is a plain synchronous array, and the bench accumulator is a register that updates only on `acc_load_o`, so the stimulus keeps inside these assumptions. `halt_i` is the only free input, and the bench toggles it both at reset and in the middle of a running loop.

// File: rtl/pair_seq_pkg.sv
package pair_seq_pkg;

    localparam int OP_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_FWAIT,
        ST_EXEC,
        ST_OPRD,
        ST_OWAIT,
        ST_WRITE,
        ST_NEXT
    } seq_state_t;

    typedef enum logic [2:0] {
        K_NOP,
        K_LOAD,
        K_STORE,
        K_JUMP,
        K_JCOND,
        K_AMOD
    } op_kind_t;

    typedef struct packed {
        op_kind_t    kind;
        logic        right_half;
        logic [1:0]  load_mode;
    } op_info_t;

    localparam logic [OP_W-1:0] OPC_LD      = 8'h01;
    localparam logic [OP_W-1:0] OPC_LD_NEG  = 8'h02;
    localparam logic [OP_W-1:0] OPC_LD_ABS  = 8'h03;
    localparam logic [OP_W-1:0] OPC_LD_NABS = 8'h04;
    localparam logic [OP_W-1:0] OPC_JMP_L   = 8'h0D;
    localparam logic [OP_W-1:0] OPC_JMP_R   = 8'h0E;
    localparam logic [OP_W-1:0] OPC_JC_L    = 8'h0F;
    localparam logic [OP_W-1:0] OPC_JC_R    = 8'h10;
    localparam logic [OP_W-1:0] OPC_FLD_L   = 8'h12;
    localparam logic [OP_W-1:0] OPC_FLD_R   = 8'h13;
    localparam logic [OP_W-1:0] OPC_ST      = 8'h21;

endpackage

// File: rtl/pair_opdec.sv
module pair_opdec
    import pair_seq_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    output op_info_t        info_o
);

    always_comb begin
        info_o = '{kind: K_NOP, right_half: 1'b0, load_mode: 2'd0};
        unique case (op_i)
            OPC_LD:      info_o = '{kind: K_LOAD,  right_half: 1'b0, load_mode: 2'd0};
            OPC_LD_NEG:  info_o = '{kind: K_LOAD,  right_half: 1'b0, load_mode: 2'd1};
            OPC_LD_ABS:  info_o = '{kind: K_LOAD,  right_half: 1'b0, load_mode: 2'd2};
            OPC_LD_NABS: info_o = '{kind: K_LOAD,  right_half: 1'b0, load_mode: 2'd3};
            OPC_ST:      info_o = '{kind: K_STORE, right_half: 1'b0, load_mode: 2'd0};
            OPC_JMP_L:   info_o = '{kind: K_JUMP,  right_half: 1'b0, load_mode: 2'd0};
            OPC_JMP_R:   info_o = '{kind: K_JUMP,  right_half: 1'b1, load_mode: 2'd0};
            OPC_JC_L:    info_o = '{kind: K_JCOND, right_half: 1'b0, load_mode: 2'd0};
            OPC_JC_R:    info_o = '{kind: K_JCOND, right_half: 1'b1, load_mode: 2'd0};
            OPC_FLD_L:   info_o = '{kind: K_AMOD,  right_half: 1'b0, load_mode: 2'd0};
            OPC_FLD_R:   info_o = '{kind: K_AMOD,  right_half: 1'b1, load_mode: 2'd0};
            default:     info_o = '{kind: K_NOP,   right_half: 1'b0, load_mode: 2'd0};
        endcase
    end

endmodule

// File: rtl/pair_half_pick.sv
module pair_half_pick
    import pair_seq_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [2*(OP_W+ADDR_W)-1:0] word_i,
    output logic [OP_W-1:0]            l_op_o,
    output logic [ADDR_W-1:0]          l_addr_o,
    output logic [OP_W-1:0]            r_op_o,
    output logic [ADDR_W-1:0]          r_addr_o,
    output logic [OP_W+ADDR_W-1:0]     r_instr_o
);

    localparam int INSTR_W = OP_W + ADDR_W;
    localparam int WORD_W  = 2 * INSTR_W;

    // halves[0] is the left (upper) instruction, halves[1] the right one
    logic [1:0][INSTR_W-1:0] halves;

    for (genvar h = 0; h < 2; h++) begin : g_half
        assign halves[h] = word_i[WORD_W-1-h*INSTR_W -: INSTR_W];
    end

    assign l_op_o    = halves[0][INSTR_W-1 -: OP_W];
    assign l_addr_o  = halves[0][ADDR_W-1:0];
    assign r_op_o    = halves[1][INSTR_W-1 -: OP_W];
    assign r_addr_o  = halves[1][ADDR_W-1:0];
    assign r_instr_o = halves[1];

endmodule

// File: rtl/pair_field_splice.sv
module pair_field_splice
    import pair_seq_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [2*(OP_W+ADDR_W)-1:0] word_i,
    input  logic [ADDR_W-1:0]          field_i,
    input  logic                       right_i,
    output logic [2*(OP_W+ADDR_W)-1:0] word_o
);

    localparam int INSTR_W = OP_W + ADDR_W;
    localparam int WORD_W  = 2 * INSTR_W;
    localparam logic [WORD_W-1:0] MASK_R = {{(WORD_W-ADDR_W){1'b0}}, {ADDR_W{1'b1}}};
    localparam logic [WORD_W-1:0] MASK_L = MASK_R << INSTR_W;

    logic [WORD_W-1:0] field_ext;

    assign field_ext = {{(WORD_W-ADDR_W){1'b0}}, field_i};

    always_comb begin
        if (right_i) begin
            word_o = (word_i & ~MASK_R) | field_ext;
        end else begin
            word_o = (word_i & ~MASK_L) | (field_ext << INSTR_W);
        end
    end

endmodule

// File: rtl/pair_sequencer.sv
module pair_sequencer
    import pair_seq_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              halt_i,
    output logic [ADDR_W-1:0]                 mem_addr_o,
    output logic                              mem_rd_o,
    output logic                              mem_wr_o,
    output logic [2*(pair_seq_pkg::OP_W+ADDR_W)-1:0] mem_wdata_o,
    input  logic [2*(pair_seq_pkg::OP_W+ADDR_W)-1:0] mem_rdata_i,
    input  logic                              mem_rvalid_i,
    input  logic [2*(pair_seq_pkg::OP_W+ADDR_W)-1:0] acc_i,
    output logic                              acc_load_o,
    output logic [1:0]                        acc_mode_o,
    output logic [2*(pair_seq_pkg::OP_W+ADDR_W)-1:0] acc_opnd_o
);

    localparam int INSTR_W = OP_W + ADDR_W;
    localparam int WORD_W  = 2 * INSTR_W;

    seq_state_t state_q, state_d;

    logic [ADDR_W-1:0]  pc_q;
    logic [ADDR_W-1:0]  mar_q;
    logic [WORD_W-1:0]  mbr_q;
    logic [OP_W-1:0]    op_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [INSTR_W-1:0] ibr_q;
    logic               ibr_vld_q;
    logic               rh_entry_q;

    op_info_t           info;
    logic               jump_take;

    logic [OP_W-1:0]    w_lop, w_rop;
    logic [ADDR_W-1:0]  w_laddr, w_raddr;
    logic [INSTR_W-1:0] w_rinstr;
    logic [WORD_W-1:0]  spliced;

    pair_opdec u_dec (
        .op_i   (op_q),
        .info_o (info)
    );

    pair_half_pick #(.ADDR_W(ADDR_W)) u_pick (
        .word_i    (mem_rdata_i),
        .l_op_o    (w_lop),
        .l_addr_o  (w_laddr),
        .r_op_o    (w_rop),
        .r_addr_o  (w_raddr),
        .r_instr_o (w_rinstr)
    );

    pair_field_splice #(.ADDR_W(ADDR_W)) u_splice (
        .word_i  (mem_rdata_i),
        .field_i (acc_i[ADDR_W-1:0]),
        .right_i (info.right_half),
        .word_o  (spliced)
    );

    // jump decision: unconditional, or conditional on a clear sign bit
    assign jump_take = (info.kind == K_JUMP) ||
                       ((info.kind == K_JCOND) && !acc_i[WORD_W-1]);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (!halt_i) state_d = ST_FETCH;
            ST_FETCH: state_d = ST_FWAIT;
            ST_FWAIT: if (mem_rvalid_i) state_d = ST_EXEC;
            ST_EXEC: begin
                unique case (info.kind)
                    K_LOAD, K_AMOD: state_d = ST_OPRD;
                    K_STORE:        state_d = ST_WRITE;
                    default:        state_d = ST_NEXT;
                endcase
            end
            ST_OPRD:  state_d = ST_OWAIT;
            ST_OWAIT: begin
                if (mem_rvalid_i) begin
                    state_d = (info.kind == K_AMOD) ? ST_WRITE : ST_NEXT;
                end
            end
            ST_WRITE: state_d = ST_NEXT;
            ST_NEXT:  state_d = ibr_vld_q ? ST_EXEC : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q       <= '0;
            mar_q      <= '0;
            mbr_q      <= '0;
            op_q       <= '0;
            addr_q     <= '0;
            ibr_q      <= '0;
            ibr_vld_q  <= 1'b0;
            rh_entry_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_FWAIT: begin
                    if (mem_rvalid_i) begin
                        pc_q  <= pc_q + 1'b1;
                        mbr_q <= mem_rdata_i;
                        if (rh_entry_q) begin
                            op_q       <= w_rop;
                            addr_q     <= w_raddr;
                            ibr_vld_q  <= 1'b0;
                            rh_entry_q <= 1'b0;
                        end else begin
                            op_q      <= w_lop;
                            addr_q    <= w_laddr;
                            ibr_q     <= w_rinstr;
                            ibr_vld_q <= 1'b1;
                        end
                    end
                end
                ST_EXEC: begin
                    mar_q <= addr_q;
                    if (info.kind == K_STORE) begin
                        mbr_q <= acc_i;
                    end
                    if (jump_take) begin
                        pc_q       <= addr_q;
                        ibr_vld_q  <= 1'b0;
                        rh_entry_q <= info.right_half;
                    end
                end
                ST_OWAIT: begin
                    if (mem_rvalid_i && (info.kind == K_AMOD)) begin
                        mbr_q <= spliced;
                    end
                end
                ST_NEXT: begin
                    if (ibr_vld_q) begin
                        op_q      <= ibr_q[INSTR_W-1 -: OP_W];
                        addr_q    <= ibr_q[ADDR_W-1:0];
                        ibr_vld_q <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_addr_o  = (state_q == ST_FETCH) ? pc_q : mar_q;
        mem_rd_o    = (state_q == ST_FETCH) || (state_q == ST_OPRD);
        mem_wr_o    = (state_q == ST_WRITE);
        mem_wdata_o = mbr_q;
        acc_load_o  = (state_q == ST_OWAIT) && mem_rvalid_i && (info.kind == K_LOAD);
        acc_mode_o  = info.load_mode;
        acc_opnd_o  = mem_rdata_i;
    end

endmodule

// File: rtl/pair_sequencer_chk.sv
module pair_sequencer_chk
    import pair_seq_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          halt_i,
    input logic                          mem_rd_o,
    input logic                          mem_wr_o,
    input logic [2*(OP_W+ADDR_W)-1:0]    mem_wdata_o,
    input logic [2*(OP_W+ADDR_W)-1:0]    mem_rdata_i,
    input logic                          mem_rvalid_i,
    input logic                          acc_load_o,
    input seq_state_t                    state_q,
    input logic [OP_W-1:0]               op_q
);

    localparam int INSTR_W = OP_W + ADDR_W;
    localparam int WORD_W  = 2 * INSTR_W;
    localparam logic [WORD_W-1:0] MASK_R = {{(WORD_W-ADDR_W){1'b0}}, {ADDR_W{1'b1}}};
    localparam logic [WORD_W-1:0] MASK_L = MASK_R << INSTR_W;

    assert_rw_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o));

    assert_read_spacing_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |=> !mem_rd_o);

    assert_load_on_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_load_o |-> mem_rvalid_i);

    assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && halt_i) |=>
            ((state_q == ST_IDLE) && !mem_rd_o && !mem_wr_o));

    assert_field_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_o && ($past(state_q) == ST_OWAIT)) |->
            ((mem_wdata_o & ~(op_q[0] ? MASK_R : MASK_L)) ==
             ($past(mem_rdata_i) & ~(op_q[0] ? MASK_R : MASK_L))));

endmodule

bind pair_sequencer pair_sequencer_chk #(.ADDR_W(ADDR_W)) chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .halt_i       (halt_i),
    .mem_rd_o     (mem_rd_o),
    .mem_wr_o     (mem_wr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_rdata_i  (mem_rdata_i),
    .mem_rvalid_i (mem_rvalid_i),
    .acc_load_o   (acc_load_o),
    .state_q      (state_q),
    .op_q         (op_q)
);

// File: tb/pair_sequencer_test.sv
module pair_sequencer_test;

    localparam int AW = 12;
    localparam int WW = 40;
    localparam logic [WW-1:0] FILL     = 40'hA5A5A5A5A5;
    localparam logic [WW-1:0] ACC_INIT = 40'h1234567890;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          halt_i = 1'b1;
    logic [AW-1:0] mem_addr_o;
    logic          mem_rd_o, mem_wr_o;
    logic [WW-1:0] mem_wdata_o;
    logic [WW-1:0] mem_rdata_i = '0;
    logic          mem_rvalid_i = 1'b0;
    logic [WW-1:0] acc = '0;
    logic          acc_load_o;
    logic [1:0]    acc_mode_o;
    logic [WW-1:0] acc_opnd_o;

    logic [WW-1:0] mem [256];

    int vectors = 0;
    int fails = 0;
    int rd_cnt, wr_cnt, ld_cnt, clash_cnt, rd0_cnt, rd80_cnt;
    logic          seen_rd;
    logic [AW-1:0] first_rd;
    logic [1:0]    last_mode;

    always #10 clk = ~clk;

    pair_sequencer #(.ADDR_W(AW)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .halt_i       (halt_i),
        .mem_addr_o   (mem_addr_o),
        .mem_rd_o     (mem_rd_o),
        .mem_wr_o     (mem_wr_o),
        .mem_wdata_o  (mem_wdata_o),
        .mem_rdata_i  (mem_rdata_i),
        .mem_rvalid_i (mem_rvalid_i),
        .acc_i        (acc),
        .acc_load_o   (acc_load_o),
        .acc_mode_o   (acc_mode_o),
        .acc_opnd_o   (acc_opnd_o)
    );

    function automatic logic [WW-1:0] acc_apply(input logic [1:0] m, input logic [WW-1:0] v);
        logic [WW-1:0] mag;
        mag = v[WW-1] ? (~v + 1'b1) : v;
        case (m)
            2'd0: return v;
            2'd1: return ~v + 1'b1;
            2'd2: return mag;
            default: return ~mag + 1'b1;
        endcase
    endfunction

    // memory: one-cycle read latency with valid
    always @(posedge clk) begin
        mem_rvalid_i <= mem_rd_o;
        mem_rdata_i  <= mem[mem_addr_o[7:0]];
        if (mem_wr_o) mem[mem_addr_o[7:0]] <= mem_wdata_o;
    end

    // arithmetic unit model
    always @(posedge clk) begin
        if (!rst_n)          acc <= ACC_INIT;
        else if (acc_load_o) acc <= acc_apply(acc_mode_o, acc_opnd_o);
    end

    // traffic monitor
    always @(posedge clk) begin
        if (!rst_n) begin
            rd_cnt <= 0; wr_cnt <= 0; ld_cnt <= 0; clash_cnt <= 0;
            rd0_cnt <= 0; rd80_cnt <= 0; seen_rd <= 1'b0; first_rd <= '0;
            last_mode <= 2'd0;
        end else begin
            if (mem_rd_o) begin
                rd_cnt <= rd_cnt + 1;
                if (!seen_rd) begin seen_rd <= 1'b1; first_rd <= mem_addr_o; end
                if (mem_addr_o == 12'h000) rd0_cnt <= rd0_cnt + 1;
                if (mem_addr_o == 12'h080) rd80_cnt <= rd80_cnt + 1;
            end
            if (mem_wr_o) wr_cnt <= wr_cnt + 1;
            if (acc_load_o) begin ld_cnt <= ld_cnt + 1; last_mode <= acc_mode_o; end
            if (mem_rd_o && mem_wr_o) clash_cnt <= clash_cnt + 1;
        end
    end

    function automatic logic [WW-1:0] pw(input logic [7:0] lo, input logic [11:0] la,
                                        input logic [7:0] ro, input logic [11:0] ra);
        return {lo, la, ro, ra};
    endfunction

    task automatic check(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = FILL;
    endtask

    task automatic run(input int cyc);
        rst_n = 1'b0;
        halt_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (cyc) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [WW-1:0] vals [8];
        logic [WW-1:0] pats [3];
        logic [WW-1:0] avals [3];
        logic [WW-1:0] svals [5];
        int snap;

        vals = '{40'h0, 40'h1, 40'h7FFFFFFFFF, 40'h8000000000,
                 40'hFFFFFFFFFF, 40'h00000ABCDE, 40'hFFF0001234, 40'h4000000001};
        pats = '{40'h0, 40'hFFFFFFFFFF, 40'h0123456789};
        avals = '{40'h0, 40'hFFFFFFFFFF, 40'h8000000ABC};
        svals = '{40'h0, 40'h5, 40'h7FFFFFFFFF, 40'hFFFFFFFFFF, 40'h8000000000};

        // R1/R10: reset, halted start, then release
        clear_mem();
        mem[0] = pw(8'h01, 12'h080, 8'h21, 12'h096);
        mem[1] = pw(8'h00, 12'h000, 8'h21, 12'h097);
        mem[2] = pw(8'h0D, 12'h002, 8'h00, 12'h000);
        mem[8'h80] = 40'h00DEADBEEF;
        rst_n = 1'b0;
        halt_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 rd at reset", {39'b0, mem_rd_o}, 40'h0);
        check("R1 wr at reset", {39'b0, mem_wr_o}, 40'h0);
        check("R1 load strobe at reset", {39'b0, acc_load_o}, 40'h0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check("R1 no access while halted", 40'(rd_cnt + wr_cnt + ld_cnt), 40'h0);
        halt_i = 1'b0;
        repeat (80) @(negedge clk);
        check("R1 first fetch address", {28'b0, first_rd}, 40'h0);
        check("R2 left then right", mem[8'h96], 40'h00DEADBEEF);
        check("R2 single fetch of word 0", 40'(rd0_cnt), 40'h1);
        check("R2 next pair runs right half", mem[8'h97], 40'h00DEADBEEF);
        // R10: halt in mid-run loop
        halt_i = 1'b1;
        repeat (20) @(negedge clk);
        snap = rd_cnt;
        repeat (30) @(negedge clk);
        check("R10 quiet while halted", 40'(rd_cnt), 40'(snap));
        halt_i = 1'b0;
        repeat (30) @(negedge clk);
        check("R10 resumes after release", {39'b0, rd_cnt > snap}, 40'h1);

        // R3/R4: load modes x value sweep, then store
        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 8; k++) begin
                clear_mem();
                mem[0] = pw(8'(m + 1), 12'h080, 8'h21, 12'h081);
                mem[1] = pw(8'h0D, 12'h001, 8'h00, 12'h000);
                mem[8'h80] = vals[k];
                run(80);
                check("R3 load strobe count", 40'(ld_cnt), 40'h1);
                check("R3 mode code", {38'b0, last_mode}, 40'(m));
                check("R4 stored accumulator", mem[8'h81], acc_apply(2'(m), vals[k]));
            end
        end

        // R8: field rewrite, both halves
        for (int s = 0; s < 2; s++) begin
            for (int p = 0; p < 3; p++) begin
                for (int a = 0; a < 3; a++) begin
                    logic [WW-1:0] exp;
                    clear_mem();
                    mem[0] = pw(8'h01, 12'h080, (s != 0) ? 8'h13 : 8'h12, 12'h082);
                    mem[1] = pw(8'h0D, 12'h001, 8'h00, 12'h000);
                    mem[8'h80] = avals[a];
                    mem[8'h82] = pats[p];
                    if (s != 0) exp = (pats[p] & ~40'hFFF) | {28'b0, avals[a][11:0]};
                    else        exp = (pats[p] & ~(40'hFFF << 20)) | ({28'b0, avals[a][11:0]} << 20);
                    run(80);
                    check("R8 field rewrite", mem[8'h82], exp);
                end
            end
        end

        // R5: unconditional jump to left half skips buffered right
        clear_mem();
        mem[0] = pw(8'h0D, 12'h003, 8'h21, 12'h090);
        mem[3] = pw(8'h01, 12'h080, 8'h21, 12'h091);
        mem[4] = pw(8'h0D, 12'h004, 8'h00, 12'h000);
        mem[8'h80] = 40'h0000C0FFEE;
        run(80);
        check("R5 buffered right skipped", mem[8'h90], FILL);
        check("R5 target pair executed", mem[8'h91], 40'h0000C0FFEE);

        // R6: jump to right half, then X+1
        clear_mem();
        mem[0] = pw(8'h0E, 12'h003, 8'h21, 12'h090);
        mem[3] = pw(8'h21, 12'h090, 8'h01, 12'h080);
        mem[4] = pw(8'h21, 12'h091, 8'h0D, 12'h004);
        mem[8'h80] = 40'h0000BADA55;
        run(100);
        check("R6 left half of target skipped", mem[8'h90], FILL);
        check("R6 right half then X+1", mem[8'h91], 40'h0000BADA55);

        // R7: conditional jumps on sign, both halves
        for (int s = 0; s < 2; s++) begin
            for (int v = 0; v < 5; v++) begin
                logic taken;
                taken = !svals[v][WW-1];
                clear_mem();
                mem[0] = pw(8'h01, 12'h080, (s != 0) ? 8'h10 : 8'h0F, 12'h003);
                mem[1] = pw(8'h21, 12'h092, 8'h0D, 12'h001);
                if (s != 0) begin
                    mem[3] = pw(8'h21, 12'h094, 8'h21, 12'h093);
                    mem[4] = pw(8'h0D, 12'h004, 8'h00, 12'h000);
                end else begin
                    mem[3] = pw(8'h21, 12'h093, 8'h0D, 12'h003);
                end
                mem[8'h80] = svals[v];
                run(100);
                check("R7 taken path", mem[8'h93], taken ? svals[v] : FILL);
                check("R7 fall-through path", mem[8'h92], taken ? FILL : svals[v]);
                if (s != 0) check("R7 right entry skips left", mem[8'h94], FILL);
            end
        end

        // R9: every undefined opcode is a no-op
        for (int op = 0; op < 256; op++) begin
            if (!(op inside {8'h01, 8'h02, 8'h03, 8'h04, 8'h0D, 8'h0E, 8'h0F,
                             8'h10, 8'h12, 8'h13, 8'h21})) begin
                clear_mem();
                mem[0] = pw(8'(op), 12'h080, 8'h21, 12'h095);
                mem[1] = pw(8'h0D, 12'h001, 8'h00, 12'h000);
                run(40);
                check("R9 no operand access", 40'(rd80_cnt + ld_cnt), 40'h0);
                check("R9 next instruction runs", mem[8'h95], ACC_INIT);
                check("R9 single write", 40'(wr_cnt), 40'h1);
            end
        end

        // R11: no read/write clash over the last run
        check("R11 read/write exclusive", 40'(clash_cnt), 40'h0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule